// File: doc/BRIEF.md
# Base and Bounds Address Translator

This block turns a logical address issued by a running context into a physical address. Each context owns a base register and a limit register. Both are loaded through a shared write port. On every access the unit adds the context's base to the logical address. It then compares the sum with the context's limit, which holds the highest physical address that context may reach. A registered result leaves the block on the clock edge after the access. That result is either a valid physical address or a protection fault.

A configuration input switches the unit to base-only operation. In that mode the relocation still happens but the limit comparison is skipped. Whatever the mode, a sum that carries out of the physical address width is always a fault. Whenever a fault is reported, the physical address output reads zero. The block is meant to sit in front of a memory port. The fault line goes to whatever logic handles protection violations.

Top module: `bb_translator`

## Requirements
- R1: After reset all result outputs are zero, every base register holds 0 and every limit register holds the all-ones physical address, so a post-reset access is translated unchanged and without fault.
- R2: An access presented with `acc_valid` high in cycle N yields, after the clock edge that ends cycle N, `out_valid`=1 and `out_paddr` = logical address + base of `acc_ctx`, when no fault applies.
- R3: With `cfg_base_only`=0, an access whose sum is greater than the context's limit sets `out_fault`=1 and `out_valid`=0; a sum exactly equal to the limit is valid.
- R4: A sum that carries out of the PADDR_W-bit physical width is a fault in both modes, whatever the limit holds.
- R5: With `cfg_base_only`=1 no limit comparison is made, so any access without a carry is valid, even when its sum exceeds the limit.
- R6: While `out_fault` is 1, `out_paddr` is zero.
- R7: A write (`wr_en`=1, `wr_sel`=0 for base, `wr_sel`=1 for limit) takes effect from the following cycle; an access in the write cycle itself is translated with the old value.
- R8: A write changes only the register of the context named by `wr_ctx`; the other contexts' bases and limits are kept.
- R9: In a cycle with `acc_valid`=0 the next result has `out_valid`=0, `out_fault`=0 and `out_paddr`=0.
- R10: `out_valid` and `out_fault` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_base_only | input | 1 | 1 = relocation only, limit comparison off |
| wr_en | input | 1 | Register write strobe |
| wr_ctx | input | CTX_W | Context whose register is written |
| wr_sel | input | 1 | 0 = base register, 1 = limit register |
| wr_data | input | PADDR_W | Value written |
| acc_valid | input | 1 | Access request this cycle |
| acc_ctx | input | CTX_W | Context issuing the access |
| acc_laddr | input | LADDR_W | Logical address of the access |
| out_valid | output | 1 | Registered: translation succeeded |
| out_fault | output | 1 | Registered: protection fault |
| out_paddr | output | PADDR_W | Registered physical address, zero unless valid |

## Verification
Some rules are checked on every cycle by the assertions. They cover the exclusivity of valid and fault, the zeroed address under a fault, and the quiet result after an idle cycle. They also cover the fault after a carry, the pass result in base-only mode, and register stability when no write occurs. Other behaviour shows only in the bench's scenarios against its behavioural model. That covers the exact relocated value and the boundary where a sum equals the limit. It also covers the old-value rule for an access in the same cycle as a write, and the isolation of one context from writes aimed at another.

// File: rtl/bb_pkg.sv
package bb_pkg;

    typedef enum logic {
        SEL_BASE  = 1'b0,
        SEL_LIMIT = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/bb_ctx_regs.sv
module bb_ctx_regs #(
    parameter int NCTX    = 4,
    parameter int PADDR_W = 16,
    localparam int CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CTX_W-1:0]   wr_ctx,
    input  logic               wr_sel,
    input  logic [PADDR_W-1:0] wr_data,
    input  logic [CTX_W-1:0]   rd_ctx,
    output logic [PADDR_W-1:0] rd_base,
    output logic [PADDR_W-1:0] rd_limit
);
    import bb_pkg::*;

    typedef struct packed {
        logic [NCTX-1:0][PADDR_W-1:0] base;
        logic [NCTX-1:0][PADDR_W-1:0] limit;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        for (int i = 0; i < NCTX; i++) begin
            if (wr_en && (wr_ctx == CTX_W'(i))) begin
                if (reg_sel_e'(wr_sel) == SEL_BASE) begin
                    regs_d.base[i] = wr_data;
                end else begin
                    regs_d.limit[i] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q.base  <= '0;
            regs_q.limit <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_base  = regs_q.base[rd_ctx];
    assign rd_limit = regs_q.limit[rd_ctx];

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_q)); // R8

endmodule

// File: rtl/bb_xlate.sv
module bb_xlate #(
    parameter int LADDR_W = 12,
    parameter int PADDR_W = 16
) (
    input  logic [LADDR_W-1:0] laddr,
    input  logic [PADDR_W-1:0] base,
    input  logic [PADDR_W-1:0] limit,
    input  logic               base_only,
    output logic [PADDR_W-1:0] paddr,
    output logic               carry,
    output logic               fault
);
    localparam int SUM_W = PADDR_W + 1;

    logic [SUM_W-1:0] sum;
    logic             over_limit;

    always_comb begin
        sum        = {1'b0, base} + SUM_W'(laddr);
        carry      = sum[PADDR_W];
        paddr      = sum[PADDR_W-1:0];
        over_limit = (sum[PADDR_W-1:0] > limit);
        fault      = carry | (~base_only & over_limit);
    end

endmodule

// File: rtl/bb_translator.sv
module bb_translator #(
    parameter int NCTX    = 4,
    parameter int LADDR_W = 12,
    parameter int PADDR_W = 16,
    localparam int CTX_W  = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_base_only,
    input  logic               wr_en,
    input  logic [CTX_W-1:0]   wr_ctx,
    input  logic               wr_sel,
    input  logic [PADDR_W-1:0] wr_data,
    input  logic               acc_valid,
    input  logic [CTX_W-1:0]   acc_ctx,
    input  logic [LADDR_W-1:0] acc_laddr,
    output logic               out_valid,
    output logic               out_fault,
    output logic [PADDR_W-1:0] out_paddr
);

    typedef struct packed {
        logic               valid;
        logic               fault;
        logic [PADDR_W-1:0] paddr;
    } res_t;

    logic [PADDR_W-1:0] sel_base, sel_limit, xl_paddr;
    logic               xl_carry, xl_fault;
    res_t               res_d, res_q;

    bb_ctx_regs #(.NCTX(NCTX), .PADDR_W(PADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_ctx   (wr_ctx),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_ctx   (acc_ctx),
        .rd_base  (sel_base),
        .rd_limit (sel_limit)
    );

    bb_xlate #(.LADDR_W(LADDR_W), .PADDR_W(PADDR_W)) u_xlate (
        .laddr     (acc_laddr),
        .base      (sel_base),
        .limit     (sel_limit),
        .base_only (cfg_base_only),
        .paddr     (xl_paddr),
        .carry     (xl_carry),
        .fault     (xl_fault)
    );

    always_comb begin
        res_d       = '0;
        res_d.fault = acc_valid & xl_fault;
        res_d.valid = acc_valid & ~xl_fault;
        if (res_d.valid) begin
            res_d.paddr = xl_paddr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign out_valid = res_q.valid;
    assign out_fault = res_q.fault;
    assign out_paddr = res_q.paddr;

    AST_VALID_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_fault)); // R10
    AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> (out_paddr == '0)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!out_valid && !out_fault && out_paddr == '0)); // R9
    AST_CARRY_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && xl_carry) |=> out_fault); // R4
    AST_BASE_ONLY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cfg_base_only && !xl_carry) |=> out_valid); // R5

endmodule

// File: tb/sim_bb_translator.sv
module sim_bb_translator;
    localparam int CLK_PERIOD = 10;
    localparam int NCTX    = 4;
    localparam int LADDR_W = 12;
    localparam int PADDR_W = 16;
    localparam int CTX_W   = 2;
    localparam int PMAX    = (1 << PADDR_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_base_only = 1'b0;
    logic wr_en = 1'b0;
    logic [CTX_W-1:0] wr_ctx = '0;
    logic wr_sel = 1'b0;
    logic [PADDR_W-1:0] wr_data = '0;
    logic acc_valid = 1'b0;
    logic [CTX_W-1:0] acc_ctx = '0;
    logic [LADDR_W-1:0] acc_laddr = '0;
    logic out_valid, out_fault;
    logic [PADDR_W-1:0] out_paddr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int m_base [NCTX];
    int m_lim  [NCTX];
    bit exp_v, exp_f;
    int exp_pa;
    string cur_tag = "R1";
    string exp_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    bb_translator #(.NCTX(NCTX), .LADDR_W(LADDR_W), .PADDR_W(PADDR_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_base_only(cfg_base_only),
        .wr_en(wr_en), .wr_ctx(wr_ctx), .wr_sel(wr_sel), .wr_data(wr_data),
        .acc_valid(acc_valid), .acc_ctx(acc_ctx), .acc_laddr(acc_laddr),
        .out_valid(out_valid), .out_fault(out_fault), .out_paddr(out_paddr)
    );

    // Behavioural reference: result of this edge's access, then apply writes.
    always @(posedge clk) begin
        exp_tag = cur_tag;
        if (!rst_n) begin
            for (int i = 0; i < NCTX; i++) begin
                m_base[i] = 0;
                m_lim[i]  = PMAX;
            end
            exp_v = 0; exp_f = 0; exp_pa = 0;
        end else begin
            if (!acc_valid) begin
                exp_v = 0; exp_f = 0; exp_pa = 0;
            end else begin
                int sum;
                bit bad;
                sum = int'(acc_laddr) + m_base[acc_ctx];
                bad = (sum > PMAX) || (!cfg_base_only && sum > m_lim[acc_ctx]);
                exp_f = bad;
                exp_v = !bad;
                exp_pa = bad ? 0 : sum;
            end
            if (wr_en) begin
                if (wr_sel) m_lim[wr_ctx] = int'(wr_data);
                else        m_base[wr_ctx] = int'(wr_data);
            end
        end
    end

    task automatic compare();
        checks++;
        if (out_valid !== exp_v || out_fault !== exp_f || int'(out_paddr) != exp_pa) begin
            errors++;
            $display("FAIL %s: actual valid=%0b fault=%0b paddr=%0h expected valid=%0b fault=%0b paddr=%0h",
                     exp_tag, out_valid, out_fault, out_paddr, exp_v, exp_f, exp_pa);
        end
        checks++;
        if (out_valid === 1'b1 && out_fault === 1'b1) begin
            errors++;
            $display("FAIL R10: actual valid=1 fault=1 expected not both");
        end
    endtask

    task automatic step(input bit av, input int ctx, input int la, input bit bo,
                        input bit we, input int wc, input bit ws, input int wd,
                        input string tag);
        acc_valid = av; acc_ctx = CTX_W'(ctx); acc_laddr = LADDR_W'(la);
        cfg_base_only = bo;
        wr_en = we; wr_ctx = CTX_W'(wc); wr_sel = ws; wr_data = PADDR_W'(wd);
        cur_tag = tag;
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input int ctx, input bit sel, input int val, input string tag);
        step(0, 0, 0, 0, 1, ctx, sel, val, tag);
    endtask

    task automatic acc(input int ctx, input int la, input bit bo, input string tag);
        step(1, ctx, la, bo, 0, 0, 0, 0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual run hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state, outputs zero even with an access requested
        rst_n = 0;
        step(1, 0, 'h123, 0, 0, 0, 0, 0, "R1");
        step(1, 1, 'h456, 0, 0, 0, 0, 0, "R1");
        rst_n = 1;
        // R1: identity translation after reset
        acc(0, 'h123, 0, "R1");
        acc(3, 'hFFF, 0, "R1");
        // R2: relocation by base 100, limit 199
        wr(1, 0, 100, "R2");
        wr(1, 1, 199, "R2");
        acc(1, 12, 0, "R2");
        acc(1, 0, 0, "R2");
        // R3 / R6: over limit faults with zero address, equality is valid
        acc(1, 350, 0, "R3");
        acc(1, 99, 0, "R3");
        acc(1, 100, 0, "R6");
        // R5: base-only skips the limit
        acc(1, 350, 1, "R5");
        acc(1, 100, 1, "R5");
        // R4: carry out is a fault in both modes
        wr(2, 0, 'hFFF0, "R4");
        acc(2, 'h20, 0, "R4");
        acc(2, 'h20, 1, "R4");
        acc(2, 'h0F, 0, "R4");
        // R7: access in the write cycle sees old base, next one sees new
        step(1, 1, 5, 0, 1, 1, 0, 150, "R7");
        acc(1, 5, 0, "R7");
        step(1, 1, 40, 0, 1, 1, 1, 150, "R7");
        acc(1, 40, 0, "R7");
        // R8: other contexts keep their values
        acc(0, 7, 0, "R8");
        acc(3, 7, 0, "R8");
        acc(2, 'h0F, 0, "R8");
        // R9: idle cycles give a quiet result
        step(0, 2, 'h20, 0, 0, 0, 0, 0, "R9");
        step(0, 1, 'hABC, 1, 0, 0, 0, 0, "R9");
        // Mixed traffic
        for (int k = 0; k < 300; k++) begin
            step($urandom_range(0, 3) != 0, $urandom_range(0, NCTX-1),
                 $urandom_range(0, (1 << LADDR_W) - 1), $urandom_range(0, 3) == 0,
                 $urandom_range(0, 3) == 0, $urandom_range(0, NCTX-1),
                 $urandom_range(0, 1),
                 ($urandom_range(0, 1) != 0) ? $urandom_range(0, PMAX) : $urandom_range(0, 'h2000),
                 "R3");
        end
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule